// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps the results of instructions that have finished executing but may not yet change machine state. Each instruction takes an entry when it is issued, in program order, and receives a tag naming that entry. When a functional unit finishes the instruction, it writes the result into the entry by tag and sets the entry's ready flag. Only the oldest entry may retire, at most one per cycle. Retiring produces a register write, a memory write, a front-end redirect or an exception report, depending on the entry's kind and its completion flags.

Operand lookup ports let consumers read a finished result straight from a live entry instead of waiting for the register file. A mispredicted branch and a faulting instruction both take effect only at the head. When either retires, every younger entry is thrown away in the same step and the next allocation follows the retiring entry.

Top module: `spec_retire_buf`

## Requirements
- R1: After reset the buffer is empty: allocReady is 1, allocTag is 0, all lookups miss, and regWe, memWe, redirect and excValid are 0.
- R2: Accepted allocations receive tags 0, 1, 2 and so on in order, wrapping modulo DEPTH. allocTag always shows the tag the next accepted allocation will get.
- R3: With DEPTH live entries, allocReady is 0 and an allocValid request is ignored: allocTag does not move and no entry is added.
- R4: A completion sets ready only on the entry its tag names. A ready entry that is not at the head never retires, so the output strobes stay low until the head entry is ready.
- R5: A ready head of kind register (code 0) without a fault raises regWe for exactly one cycle, with regAddr set to its destination and regData set to its result. The head then advances by one.
- R6: A ready head of kind store (code 1) without a fault raises memWe, with memAddr set to the completion address and memData set to the result. No register strobe is raised.
- R7: A ready head of kind branch (code 2) marked mispredicted raises redirect, with redirectPc set to the completion address. All younger entries are discarded, so none of them ever raises a strobe, and allocTag becomes the branch tag plus one. A correctly predicted branch, and kind none (code 3), retire without any strobe.
- R8: A fault flag given at completion is reported only when that entry reaches the head. excValid is raised with excTag set to the entry's tag, no register or memory write happens, and all younger entries are discarded.
- R9: Each lookup port hits only when its tag names a live, ready entry, and then returns that entry's result. Entries that are not yet complete, have retired or have been flushed miss.
- R10: During a retirement that flushes (R7, R8), allocReady is 0 and no allocation is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Request to allocate an entry |
| allocKind | input | 2 | Kind: 0 register, 1 store, 2 branch, 3 none |
| allocDest | input | REG_W | Destination register number |
| allocReady | output | 1 | Allocation accepted this cycle if requested |
| allocTag | output | TAG_W | Tag of the next allocated entry |
| doneValid | input | 1 | Completion write strobe |
| doneTag | input | TAG_W | Entry being completed |
| doneValue | input | DATA_W | Result value |
| doneAddr | input | ADDR_W | Store address or branch target |
| doneExc | input | 1 | Instruction faulted |
| doneMiss | input | 1 | Branch was mispredicted |
| lookTag | input | NUM_LOOK*TAG_W | Lookup tags, one field per port |
| lookHit | output | NUM_LOOK | Lookup found a live ready entry |
| lookValue | output | NUM_LOOK*DATA_W | Lookup result values |
| regWe | output | 1 | Register write at retirement |
| regAddr | output | REG_W | Register number to write |
| regData | output | DATA_W | Register write data |
| memWe | output | 1 | Memory write at retirement |
| memAddr | output | ADDR_W | Memory write address |
| memData | output | DATA_W | Memory write data |
| redirect | output | 1 | Mispredicted branch retired |
| redirectPc | output | ADDR_W | Correct target address |
| excValid | output | 1 | Faulting instruction at head |
| excTag | output | TAG_W | Tag of the faulting entry |

## Verification
The embedded checks assume that a completion only ever names an entry that is live and not yet ready. They also assume that each slot is empty when it is allocated. The stimulus draws a completion tag at random and sends the completion only if the bench's own model marks that tag as live and unfinished. Lookup tags are left unrestricted, because a lookup to a dead entry must simply miss. Fault and mispredict flags are rare in the random stream so that long runs of in-order retirement occur between flushes. Directed sequences fill the buffer, complete entries out of order, and retire a mispredicted branch and a faulting entry while finished younger entries sit behind them.

// File: rtl/srb_pkg.sv
package srb_pkg;

  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2,
    KIND_NONE   = 2'd3
  } kind_e;

  // strobes from control to entry storage
  typedef struct packed {
    logic allocEn;
    logic commitEn;
    logic flushAll;
  } ctlStrobe_t;

  // state of the oldest entry, seen by control
  typedef struct packed {
    logic  valid;
    logic  ready;
    logic  exc;
    logic  miss;
    kind_e kind;
  } headStat_t;

endpackage

// File: rtl/srb_ctrl.sv
module srb_ctrl
  import srb_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       allocValid,
  input  headStat_t  headStat,
  output ctlStrobe_t ctl,
  output logic [IW-1:0] allocIdx,
  output logic [IW-1:0] headIdx,
  output logic       allocReady,
  output logic       regWe,
  output logic       memWe,
  output logic       redirect,
  output logic       excValid
);

  localparam int PW = IW + 1;

  logic [PW-1:0] headPtr, tailPtr, occupancy, headNext;
  logic full, fire, isMiss, flushNow;

  assign occupancy = tailPtr - headPtr;
  assign full      = (occupancy == PW'(DEPTH));
  assign headNext  = headPtr + PW'(1);
  assign headIdx   = headPtr[IW-1:0];
  assign allocIdx  = tailPtr[IW-1:0];

  // retirement decision on the oldest entry
  assign fire     = headStat.valid && headStat.ready;
  assign isMiss   = (headStat.kind == KIND_BRANCH) && headStat.miss;
  assign flushNow = fire && (headStat.exc || isMiss);

  assign allocReady = !full && !flushNow;

  always_comb begin
    ctl          = '0;
    ctl.allocEn  = allocValid && allocReady;
    ctl.commitEn = fire;
    ctl.flushAll = flushNow;
  end

  assign regWe    = fire && !headStat.exc && (headStat.kind == KIND_REG);
  assign memWe    = fire && !headStat.exc && (headStat.kind == KIND_STORE);
  assign redirect = fire && !headStat.exc && isMiss;
  assign excValid = fire && headStat.exc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else if (flushNow) begin
      headPtr <= headNext;
      tailPtr <= headNext;
    end else begin
      if (fire)        headPtr <= headNext;
      if (ctl.allocEn) tailPtr <= tailPtr + PW'(1);
    end
  end

  // R3: occupancy never exceeds the capacity
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= PW'(DEPTH));

  // R7, R8: a flushing retirement leaves the buffer empty
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.flushAll |=> (tailPtr == headPtr));

  // R5: at most one retirement effect per cycle
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({regWe, memWe, redirect, excValid}));

  // R10: no allocation accepted while flushing
  a_r10_no_alloc_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.flushAll |=> (tailPtr == $past(headNext)));

endmodule

// File: rtl/srb_data.sv
module srb_data
  import srb_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int REG_W    = 5,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 32,
  parameter int NUM_LOOK = 2,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        ctl,
  input  logic [IW-1:0]     allocIdx,
  input  logic [IW-1:0]     headIdx,
  input  logic [1:0]        allocKind,
  input  logic [REG_W-1:0]  allocDest,
  input  logic              doneValid,
  input  logic [IW-1:0]     doneTag,
  input  logic [DATA_W-1:0] doneValue,
  input  logic [ADDR_W-1:0] doneAddr,
  input  logic              doneExc,
  input  logic              doneMiss,
  input  logic [NUM_LOOK*IW-1:0]     lookTag,
  output logic [NUM_LOOK-1:0]        lookHit,
  output logic [NUM_LOOK*DATA_W-1:0] lookValue,
  output headStat_t         headStat,
  output logic [REG_W-1:0]  headDest,
  output logic [DATA_W-1:0] headValue,
  output logic [ADDR_W-1:0] headAddr
);

  logic [DEPTH-1:0] validQ, readyQ, excQ, missQ;
  kind_e            kindQ  [DEPTH];
  logic [REG_W-1:0] destQ  [DEPTH];
  logic [DATA_W-1:0] valueQ [DEPTH];
  logic [ADDR_W-1:0] addrQ  [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      validQ <= '0;
      readyQ <= '0;
      excQ   <= '0;
      missQ  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        kindQ[i]  <= KIND_NONE;
        destQ[i]  <= '0;
        valueQ[i] <= '0;
        addrQ[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ctl.flushAll)
          validQ[i] <= 1'b0;
        else if (ctl.commitEn && headIdx == IW'(i))
          validQ[i] <= 1'b0;
        else if (ctl.allocEn && allocIdx == IW'(i))
          validQ[i] <= 1'b1;

        if (ctl.allocEn && allocIdx == IW'(i)) begin
          readyQ[i] <= 1'b0;
          excQ[i]   <= 1'b0;
          missQ[i]  <= 1'b0;
          kindQ[i]  <= kind_e'(allocKind);
          destQ[i]  <= allocDest;
        end else if (doneValid && doneTag == IW'(i) && validQ[i]) begin
          readyQ[i] <= 1'b1;
          excQ[i]   <= doneExc;
          missQ[i]  <= doneMiss;
          valueQ[i] <= doneValue;
          addrQ[i]  <= doneAddr;
        end
      end
    end
  end

  always_comb begin
    headStat       = '0;
    headStat.valid = validQ[headIdx];
    headStat.ready = readyQ[headIdx];
    headStat.exc   = excQ[headIdx];
    headStat.miss  = missQ[headIdx];
    headStat.kind  = kindQ[headIdx];
  end

  assign headDest  = destQ[headIdx];
  assign headValue = valueQ[headIdx];
  assign headAddr  = addrQ[headIdx];

  for (genvar k = 0; k < NUM_LOOK; k++) begin : g_look
    logic [IW-1:0] slot;
    assign slot = lookTag[k*IW +: IW];
    assign lookHit[k] = validQ[slot] & readyQ[slot];
    assign lookValue[k*DATA_W +: DATA_W] = valueQ[slot];
  end

  // R4: retirement only of a live, completed head
  a_r4_commit_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.commitEn |-> (validQ[headIdx] && readyQ[headIdx]));

  // R4: completions only name live, unfinished entries
  a_r4_done_targets_live: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |-> (validQ[doneTag] && !readyQ[doneTag]));

  // R2: allocation never lands on a live slot
  a_r2_alloc_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.allocEn |-> !validQ[allocIdx]);

  // R7: after a flush no entry remains live
  a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.flushAll |=> (validQ == '0));

endmodule

// File: rtl/spec_retire_buf.sv
module spec_retire_buf
  import srb_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int REG_W    = 5,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 32,
  parameter int NUM_LOOK = 2,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       allocValid,
  input  logic [1:0]                 allocKind,
  input  logic [REG_W-1:0]           allocDest,
  output logic                       allocReady,
  output logic [TAG_W-1:0]           allocTag,
  input  logic                       doneValid,
  input  logic [TAG_W-1:0]           doneTag,
  input  logic [DATA_W-1:0]          doneValue,
  input  logic [ADDR_W-1:0]          doneAddr,
  input  logic                       doneExc,
  input  logic                       doneMiss,
  input  logic [NUM_LOOK*TAG_W-1:0]  lookTag,
  output logic [NUM_LOOK-1:0]        lookHit,
  output logic [NUM_LOOK*DATA_W-1:0] lookValue,
  output logic                       regWe,
  output logic [REG_W-1:0]           regAddr,
  output logic [DATA_W-1:0]          regData,
  output logic                       memWe,
  output logic [ADDR_W-1:0]          memAddr,
  output logic [DATA_W-1:0]          memData,
  output logic                       redirect,
  output logic [ADDR_W-1:0]          redirectPc,
  output logic                       excValid,
  output logic [TAG_W-1:0]           excTag
);

  ctlStrobe_t        ctl;
  headStat_t         headStat;
  logic [TAG_W-1:0]  allocIdx, headIdx;
  logic [REG_W-1:0]  headDest;
  logic [DATA_W-1:0] headValue;
  logic [ADDR_W-1:0] headAddr;

  srb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .allocValid (allocValid),
    .headStat   (headStat),
    .ctl        (ctl),
    .allocIdx   (allocIdx),
    .headIdx    (headIdx),
    .allocReady (allocReady),
    .regWe      (regWe),
    .memWe      (memWe),
    .redirect   (redirect),
    .excValid   (excValid)
  );

  srb_data #(
    .DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .NUM_LOOK(NUM_LOOK)
  ) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .allocIdx  (allocIdx),
    .headIdx   (headIdx),
    .allocKind (allocKind),
    .allocDest (allocDest),
    .doneValid (doneValid),
    .doneTag   (doneTag),
    .doneValue (doneValue),
    .doneAddr  (doneAddr),
    .doneExc   (doneExc),
    .doneMiss  (doneMiss),
    .lookTag   (lookTag),
    .lookHit   (lookHit),
    .lookValue (lookValue),
    .headStat  (headStat),
    .headDest  (headDest),
    .headValue (headValue),
    .headAddr  (headAddr)
  );

  assign allocTag   = allocIdx;
  assign regAddr    = headDest;
  assign regData    = headValue;
  assign memAddr    = headAddr;
  assign memData    = headValue;
  assign redirectPc = headAddr;
  assign excTag     = headIdx;

endmodule

// File: tb/spec_retire_buf_test.sv
`timescale 1ns/1ps
module spec_retire_buf_test;
  localparam int DEPTH = 8, IW = 3, REG_W = 5, DATA_W = 32, ADDR_W = 32, NL = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, allocValid, allocReady, doneValid, doneExc, doneMiss;
  logic [1:0] allocKind;
  logic [REG_W-1:0] allocDest, regAddr;
  logic [IW-1:0] allocTag, doneTag, excTag;
  logic [DATA_W-1:0] doneValue, regData, memData;
  logic [ADDR_W-1:0] doneAddr, memAddr, redirectPc;
  logic [NL*IW-1:0] lookTag;
  logic [NL-1:0] lookHit;
  logic [NL*DATA_W-1:0] lookValue;
  logic regWe, memWe, redirect, excValid;

  spec_retire_buf uut (.*);

  int checks = 0, errors = 0;

  // bench model of the buffer
  bit mV[DEPTH], mR[DEPTH], mE[DEPTH], mM[DEPTH];
  logic [1:0] mK[DEPTH];
  logic [REG_W-1:0] mD[DEPTH];
  logic [DATA_W-1:0] mVal[DEPTH];
  logic [ADDR_W-1:0] mAdr[DEPTH];
  int mHead = 0, mTail = 0;
  int forceLook = -1;

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic bit expFire();
    return mV[mHead % DEPTH] && mR[mHead % DEPTH];
  endfunction
  function automatic bit expExc();
    return expFire() && mE[mHead % DEPTH];
  endfunction
  function automatic bit expMiss();
    int h = mHead % DEPTH;
    return expFire() && !mE[h] && mK[h] == 2'd2 && mM[h];
  endfunction
  function automatic bit expReady();
    return (mTail - mHead < DEPTH) && !expExc() && !expMiss();
  endfunction

  task automatic compare();
    int h = mHead % DEPTH;
    bit fire = expFire();
    bit eReg = fire && !mE[h] && mK[h] == 2'd0;
    bit eMem = fire && !mE[h] && mK[h] == 2'd1;
    chk("R8 excValid", 64'(excValid), 64'(expExc()));
    chk("R7 redirect", 64'(redirect), 64'(expMiss()));
    chk("R5 regWe", 64'(regWe), 64'(eReg));
    chk("R6 memWe", 64'(memWe), 64'(eMem));
    if (eReg) begin
      chk("R5 regAddr", 64'(regAddr), 64'(mD[h]));
      chk("R5 regData", 64'(regData), 64'(mVal[h]));
    end
    if (eMem) begin
      chk("R6 memAddr", 64'(memAddr), 64'(mAdr[h]));
      chk("R6 memData", 64'(memData), 64'(mVal[h]));
    end
    if (expMiss()) chk("R7 redirectPc", 64'(redirectPc), 64'(mAdr[h]));
    if (expExc())  chk("R8 excTag", 64'(excTag), 64'(h));
    chk("R3 R10 allocReady", 64'(allocReady), 64'(expReady()));
    chk("R2 allocTag", 64'(allocTag), 64'(mTail % DEPTH));
    for (int k = 0; k < NL; k++) begin
      int t = int'(lookTag[k*IW +: IW]);
      bit hit = mV[t] && mR[t];
      chk("R9 lookHit", 64'(lookHit[k]), 64'(hit));
      if (hit) chk("R9 lookValue", 64'(lookValue[k*DATA_W +: DATA_W]), 64'(mVal[t]));
    end
  endtask

  task automatic step(bit aV, logic [1:0] aK, logic [REG_W-1:0] aD,
                      bit dV, int dT, logic [DATA_W-1:0] dVal,
                      logic [ADDR_W-1:0] dAdr, bit dE, bit dM);
    bit fire, flush, acc;
    allocValid = aV; allocKind = aK; allocDest = aD;
    doneValid = dV; doneTag = IW'(dT); doneValue = dVal; doneAddr = dAdr;
    doneExc = dE; doneMiss = dM;
    for (int k = 0; k < NL; k++) lookTag[k*IW +: IW] = IW'($urandom % DEPTH);
    if (forceLook >= 0) lookTag[IW-1:0] = IW'(forceLook);
    fire  = expFire();
    flush = expExc() || expMiss();
    acc   = aV && expReady();
    if (dV && mV[dT]) begin
      mR[dT] = 1; mVal[dT] = dVal; mAdr[dT] = dAdr; mE[dT] = dE; mM[dT] = dM;
    end
    if (flush) begin
      for (int i = 0; i < DEPTH; i++) mV[i] = 0;
      mHead = mHead + 1;
      mTail = mHead;
    end else begin
      if (fire) begin mV[mHead % DEPTH] = 0; mHead = mHead + 1; end
      if (acc) begin
        int t = mTail % DEPTH;
        mV[t] = 1; mR[t] = 0; mE[t] = 0; mM[t] = 0; mK[t] = aK; mD[t] = aD;
        mTail = mTail + 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    step(0, 2'd0, '0, 0, 0, '0, '0, 0, 0);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int seed = 32'h1d5e;
    int bTag, xTag;
    void'($urandom(seed));
    rst_n = 0; allocValid = 0; allocKind = 0; allocDest = 0; doneValid = 0;
    doneTag = 0; doneValue = 0; doneAddr = 0; doneExc = 0; doneMiss = 0; lookTag = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 allocReady", 64'(allocReady), 64'd1);
    chk("R1 allocTag", 64'(allocTag), 64'd0);
    chk("R1 strobes", 64'({regWe, memWe, redirect, excValid}), 64'd0);
    chk("R1 lookHit", 64'(lookHit), 64'd0);
    compare();

    // R2, R3: fill the buffer, then request once more
    for (int i = 0; i < DEPTH; i++) step(1, 2'd0, REG_W'(i + 1), 0, 0, '0, '0, 0, 0);
    chk("R3 full allocReady", 64'(allocReady), 64'd0);
    step(1, 2'd0, 5'd31, 0, 0, '0, '0, 0, 0);
    chk("R3 tag held when full", 64'(allocTag), 64'd0);

    // R4, R9: complete a young entry first; nothing retires
    forceLook = 3;
    step(0, 2'd0, '0, 1, 3, 32'hA3A3, '0, 0, 0);
    chk("R4 no early commit", 64'(regWe), 64'd0);
    chk("R9 hit on ready entry", 64'(lookHit[0]), 64'd1);
    forceLook = -1;
    for (int i = 0; i < DEPTH; i++)
      if (i != 3) step(0, 2'd0, '0, 1, i, DATA_W'(32'h100 + i), '0, 0, 0);
    repeat (DEPTH) idle();

    // R7: mispredicted branch with finished younger entries
    bTag = mTail % DEPTH;
    step(1, 2'd2, '0, 0, 0, '0, '0, 0, 0);
    step(1, 2'd0, 5'd7, 0, 0, '0, '0, 0, 0);
    step(1, 2'd1, '0, 0, 0, '0, '0, 0, 0);
    step(0, 2'd0, '0, 1, (bTag + 1) % DEPTH, 32'h55, '0, 0, 0);
    step(0, 2'd0, '0, 1, (bTag + 2) % DEPTH, 32'h66, 32'h400, 0, 0);
    step(0, 2'd0, '0, 1, bTag, '0, 32'hBEEF0, 0, 1);
    chk("R7 redirect at head", 64'(redirect), 64'd1);
    idle();
    chk("R7 tail after branch", 64'(allocTag), 64'((bTag + 1) % DEPTH));

    // R8: fault reported only at head
    step(1, 2'd0, 5'd3, 0, 0, '0, '0, 0, 0);
    xTag = (mTail) % DEPTH;
    step(1, 2'd1, '0, 0, 0, '0, '0, 0, 0);
    step(1, 2'd0, 5'd4, 0, 0, '0, '0, 0, 0);
    step(0, 2'd0, '0, 1, (xTag + 1) % DEPTH, 32'h77, '0, 0, 0);
    step(0, 2'd0, '0, 1, xTag, 32'h88, 32'h500, 1, 0);
    chk("R8 held behind head", 64'(excValid), 64'd0);
    step(0, 2'd0, '0, 1, (xTag + DEPTH - 1) % DEPTH, 32'h99, '0, 0, 0);
    chk("R5 older entry retires first", 64'(regWe), 64'd1);
    idle();
    chk("R8 exc at head", 64'(excValid), 64'd1);
    chk("R8 no store write", 64'(memWe), 64'd0);
    idle();
    chk("R8 tail after fault", 64'(allocTag), 64'((xTag + 1) % DEPTH));

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int t = int'($urandom % DEPTH);
      logic [1:0] k = 2'($urandom % 4);
      bit dv = mV[t] && !mR[t] && ($urandom % 3 != 0);
      bit de = ($urandom % 24 == 0);
      bit dm = (mK[t] == 2'd2) && ($urandom % 4 == 0);
      step(($urandom % 2) == 1, k, REG_W'($urandom), dv, t,
           DATA_W'($urandom), ADDR_W'($urandom), de, dm);
    end
    finishRun();
  end
endmodule